// File: doc/BRIEF.md
# Console Serial Port Interrupt Requester

This block holds the interrupt-request state for a console serial port that has a receive side and a transmit side. Each side keeps a ready flag and an interrupt-enable bit. Register-write strobes, a transmit-complete pulse, a data-arrival pulse, a receive-buffer read strobe and a transmit-buffer load strobe update these flags. From them the block derives one interrupt request line, a fixed priority level, and a side select that tells the CPU which vector to use.

A side's pending flip-flop arms only when "enable AND ready" goes from 0 to 1. It is withdrawn at once if either term drops. An acknowledge also clears it, and while both terms stay at 1 it cannot arm again. This mix of edge and level behaviour prevents a transmit livelock: if the transmitter is still idle and still enabled after the acknowledge, it must not request again. The serial shifter, baud generator and bus decode sit outside the block and reach it only as single-cycle strobes.

Top module: `cons_irq_ctl`

## Requirements
- R1: After reset both enables are 0, transmit ready is 1, receive ready is 0, and no request is raised.
- R2: A ready flag that rises while its side's enable is 1 raises a request from that side in the following cycle.
- R3: Writing an enable to 1 while that side's ready is already 1 raises a request. Writing 1 when the enable is already 1 raises none.
- R4: Writing an enable to 0 withdraws that side's pending request in the following cycle, even if it was never acknowledged.
- R5: An acknowledge while a request is raised clears only the side named by the side select. No new request from that side appears while its enable and ready both stay at 1. An acknowledge with no request raised changes nothing.
- R6: Loading the transmit buffer clears transmit ready and the transmit pending request. A load wins over a transmit-complete pulse in the same cycle.
- R7: A data-arrival pulse sets receive ready. A receive-buffer read clears receive ready and the receive pending request. A read and an arrival in the same cycle leave receive ready at 1 and raise a fresh request when the receive enable is 1.
- R8: I/O reset clears both pending requests and leaves enables and ready flags unchanged. A side then needs a new 0-to-1 change of enable AND ready to request again.
- R9: A write to the initialise register sets both enables to 0, transmit ready to 1, receive ready to 0, and drops any request. It wins over every other event in the same cycle.
- R10: While a request is raised, the level output is 0x14; otherwise it is 0. Side select 0 means receive and 1 means transmit. When both sides are pending, receive is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioReset | input | 1 | I/O reset pulse, clears pending requests |
| wrRxCsr | input | 1 | Write strobe for the receive enable bit |
| wrTxCsr | input | 1 | Write strobe for the transmit enable bit |
| wrIeBit | input | 1 | Enable value carried by either write strobe |
| rdRxBuf | input | 1 | Receive buffer read strobe |
| wrTxBuf | input | 1 | Transmit buffer load strobe |
| wrBootReg | input | 1 | Initialise register write strobe |
| txDonePulse | input | 1 | Transmitter finished a character |
| rxArrivePulse | input | 1 | Receiver has a new character |
| intAck | input | 1 | CPU acknowledges the presented request |
| irqReq | output | 1 | Interrupt request |
| irqSide | output | 1 | 0 = receive vector, 1 = transmit vector |
| irqLevel | output | 5 | Priority level, 0x14 while requesting |
| rxIe | output | 1 | Receive enable read-back |
| rxDone | output | 1 | Receive ready read-back |
| txIe | output | 1 | Transmit enable read-back |
| txDone | output | 1 | Transmit ready read-back |

## Verification
An acknowledge of one side can fall in the same cycle as the other side's ready flag rising. The bench drives an acknowledge of a pending receive request in the same cycle as a transmit-complete pulse, then expects the receive request to be gone and a transmit request in its place. A buffer read can also coincide with an arrival. That case is judged by whether receive ready stays set and a fresh request shows. A near-exhaustive sweep covers every old enable, ready and new enable combination on each side, and computes the expected request as the 0-to-1 change of their AND.

// File: rtl/cons_irq_pkg.sv
package cons_irq_pkg;
  localparam int SIDES = 2;
  localparam int RX = 0;
  localparam int TX = 1;

  typedef struct packed {
    logic setIe;
    logic clrIe;
    logic setDone;
    logic clrDone;
    logic fresh;
    logic ack;
    logic clrPend;
  } sideStrobe_t;
endpackage

// File: rtl/cons_irq_ctrl.sv
module cons_irq_ctrl
  import cons_irq_pkg::*;
(
  input  logic wrRxCsr,
  input  logic wrTxCsr,
  input  logic wrIeBit,
  input  logic rdRxBuf,
  input  logic wrTxBuf,
  input  logic wrBootReg,
  input  logic txDonePulse,
  input  logic rxArrivePulse,
  input  logic intAck,
  input  logic ioReset,
  input  logic irqReq,
  input  logic irqSide,
  output sideStrobe_t [SIDES-1:0] strb
);
  always_comb begin
    strb = '0;
    // acknowledge routed only to the side being presented (R5)
    strb[RX].ack = intAck & irqReq & ~irqSide;
    strb[TX].ack = intAck & irqReq & irqSide;
    strb[RX].clrPend = ioReset;
    strb[TX].clrPend = ioReset;
    if (wrBootReg) begin
      // initialise write overrides every other update (R9)
      strb[RX].clrIe   = 1'b1;
      strb[TX].clrIe   = 1'b1;
      strb[RX].clrDone = 1'b1;
      strb[TX].setDone = 1'b1;
    end else begin
      strb[RX].setIe   = wrRxCsr & wrIeBit;
      strb[RX].clrIe   = wrRxCsr & ~wrIeBit;
      strb[TX].setIe   = wrTxCsr & wrIeBit;
      strb[TX].clrIe   = wrTxCsr & ~wrIeBit;
      strb[RX].setDone = rxArrivePulse;
      strb[RX].clrDone = rdRxBuf & ~rxArrivePulse;
      strb[RX].fresh   = rdRxBuf & rxArrivePulse;
      strb[TX].clrDone = wrTxBuf;
      strb[TX].setDone = txDonePulse & ~wrTxBuf;
    end
  end
endmodule

// File: rtl/cons_irq_dp.sv
module cons_irq_dp
  import cons_irq_pkg::*;
#(
  parameter logic [SIDES-1:0] DONE_RST = 2'b10
) (
  input  logic clk,
  input  logic rstN,
  input  sideStrobe_t [SIDES-1:0] strb,
  output logic [SIDES-1:0] ieQ,
  output logic [SIDES-1:0] doneQ,
  output logic [SIDES-1:0] pendQ,
  output logic irqReq,
  output logic irqSide
);
  for (genvar g = 0; g < SIDES; g++) begin : gSide
    logic ie, done, pend;
    logic ieN, doneN, condNow, condNext, pendN;

    always_comb begin
      ieN      = strb[g].clrIe ? 1'b0 : (strb[g].setIe ? 1'b1 : ie);
      doneN    = strb[g].clrDone ? 1'b0 : (strb[g].setDone ? 1'b1 : done);
      condNow  = ie & done;
      condNext = ieN & doneN;
      // arm on a rising edge, hold only while the condition stays true
      pendN    = ~strb[g].clrPend & condNext &
                 (~condNow | strb[g].fresh | (pend & ~strb[g].ack));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ie   <= 1'b0;
        done <= DONE_RST[g];
        pend <= 1'b0;
      end else begin
        ie   <= ieN;
        done <= doneN;
        pend <= pendN;
      end
    end

    assign ieQ[g]   = ie;
    assign doneQ[g] = done;
    assign pendQ[g] = pend;

    AST_PEND_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
      pend |-> (ie && done)); // R4
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
      (strb[g].ack && !strb[g].fresh) |=> !pend); // R5
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
      (ie && done && !pend && !strb[g].fresh && !strb[g].clrIe && !strb[g].clrDone)
        |=> !pend); // R5
  end

  // receive is presented ahead of transmit
  assign irqReq  = |pendQ;
  assign irqSide = ~pendQ[RX];
endmodule

// File: rtl/cons_irq_ctl.sv
module cons_irq_ctl
  import cons_irq_pkg::*;
#(
  parameter int LEVEL_W = 5,
  parameter logic [LEVEL_W-1:0] IRQ_LEVEL = 5'h14
) (
  input  logic clk,
  input  logic rstN,
  input  logic ioReset,
  input  logic wrRxCsr,
  input  logic wrTxCsr,
  input  logic wrIeBit,
  input  logic rdRxBuf,
  input  logic wrTxBuf,
  input  logic wrBootReg,
  input  logic txDonePulse,
  input  logic rxArrivePulse,
  input  logic intAck,
  output logic irqReq,
  output logic irqSide,
  output logic [LEVEL_W-1:0] irqLevel,
  output logic rxIe,
  output logic rxDone,
  output logic txIe,
  output logic txDone
);
  sideStrobe_t [SIDES-1:0] strb;
  logic [SIDES-1:0] ieQ, doneQ, pendQ;

  cons_irq_ctrl i_ctrl (
    .wrRxCsr(wrRxCsr), .wrTxCsr(wrTxCsr), .wrIeBit(wrIeBit),
    .rdRxBuf(rdRxBuf), .wrTxBuf(wrTxBuf), .wrBootReg(wrBootReg),
    .txDonePulse(txDonePulse), .rxArrivePulse(rxArrivePulse),
    .intAck(intAck), .ioReset(ioReset),
    .irqReq(irqReq), .irqSide(irqSide), .strb(strb)
  );

  cons_irq_dp #(.DONE_RST(2'b10)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ieQ(ieQ), .doneQ(doneQ), .pendQ(pendQ),
    .irqReq(irqReq), .irqSide(irqSide)
  );

  assign irqLevel = irqReq ? IRQ_LEVEL : '0;
  assign rxIe   = ieQ[RX];
  assign txIe   = ieQ[TX];
  assign rxDone = doneQ[RX];
  assign txDone = doneQ[TX];

  AST_IORESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ioReset |=> !irqReq); // R8
  AST_BOOT_STATE: assert property (@(posedge clk) disable iff (!rstN)
    wrBootReg |=> (!rxIe && !txIe && txDone && !rxDone && !irqReq)); // R9
  AST_TXLOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrTxBuf && !wrBootReg) |=> (!txDone && !pendQ[TX])); // R6
  AST_RX_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (rxIe && rxDone && !$past(rxIe && rxDone)) |-> (irqReq && !irqSide)); // R10
endmodule

// File: tb/test_cons_irq_ctl.sv
module test_cons_irq_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioReset = 0, wrRxCsr = 0, wrTxCsr = 0, wrIeBit = 0, rdRxBuf = 0;
  logic wrTxBuf = 0, wrBootReg = 0, txDonePulse = 0, rxArrivePulse = 0, intAck = 0;
  logic irqReq, irqSide, rxIe, rxDone, txIe, txDone;
  logic [4:0] irqLevel;
  int nRun = 0, nFail = 0;

  always #5 clk = ~clk;

  cons_irq_ctl i_cons_irq_ctl (
    .clk(clk), .rstN(rstN), .ioReset(ioReset), .wrRxCsr(wrRxCsr),
    .wrTxCsr(wrTxCsr), .wrIeBit(wrIeBit), .rdRxBuf(rdRxBuf), .wrTxBuf(wrTxBuf),
    .wrBootReg(wrBootReg), .txDonePulse(txDonePulse), .rxArrivePulse(rxArrivePulse),
    .intAck(intAck), .irqReq(irqReq), .irqSide(irqSide), .irqLevel(irqLevel),
    .rxIe(rxIe), .rxDone(rxDone), .txIe(txIe), .txDone(txDone)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock with the currently driven strobes, then release them
  task automatic cyc();
    @(negedge clk);
    {ioReset, wrRxCsr, wrTxCsr, wrIeBit, rdRxBuf, wrTxBuf} = '0;
    {wrBootReg, txDonePulse, rxArrivePulse, intAck} = '0;
  endtask

  task automatic wrIe(int side, logic v);
    if (side == 0) wrRxCsr = 1'b1; else wrTxCsr = 1'b1;
    wrIeBit = v;
    cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", {7'b0, irqReq}, 8'd0);
    chk("R1 flags", {4'b0, rxIe, rxDone, txIe, txDone}, 8'b0001);

    // R2 transmit ready rises under enable
    wrTxBuf = 1; cyc();
    chk("R6 load clears txDone", {7'b0, txDone}, 8'd0);
    wrIe(1, 1'b1);
    chk("R2 no req before done", {7'b0, irqReq}, 8'd0);
    txDonePulse = 1; cyc();
    chk("R2 tx req", {6'b0, irqReq, irqSide}, 8'b11);
    chk("R10 level", {3'b0, irqLevel}, 8'h14);

    // R5 livelock guard
    intAck = 1; cyc();
    chk("R5 ack clears", {7'b0, irqReq}, 8'd0);
    repeat (5) cyc();
    chk("R5 no retrigger", {5'b0, irqReq, txIe, txDone}, 8'b011);
    chk("R10 level idle", {3'b0, irqLevel}, 8'h00);

    // R3/R4 enable toggling
    wrIe(1, 1'b0);
    wrIe(1, 1'b1);
    chk("R3 enable while ready", {7'b0, irqReq}, 8'd1);
    wrIe(1, 1'b0);
    chk("R4 withdraw", {7'b0, irqReq}, 8'd0);
    wrIe(1, 1'b1);
    chk("R3 re-arm", {7'b0, irqReq}, 8'd1);
    wrTxBuf = 1; cyc();
    chk("R6 load drops req", {6'b0, irqReq, txDone}, 8'b00);

    // R6 load and complete together
    wrTxBuf = 1; txDonePulse = 1; cyc();
    chk("R6 load wins", {6'b0, irqReq, txDone}, 8'b00);

    // R7 receive path
    wrIe(0, 1'b1);
    rxArrivePulse = 1; cyc();
    chk("R7 rx req", {5'b0, irqReq, irqSide, rxDone}, 8'b101);
    rdRxBuf = 1; cyc();
    chk("R7 read clears", {6'b0, irqReq, rxDone}, 8'b00);
    rxArrivePulse = 1; cyc();
    intAck = 1; cyc();
    chk("R5 rx ack", {6'b0, irqReq, rxDone}, 8'b01);
    rdRxBuf = 1; rxArrivePulse = 1; cyc();
    chk("R7 read+arrive fresh", {5'b0, irqReq, irqSide, rxDone}, 8'b101);

    // R10 priority and R5 same-cycle ack with other side rising
    intAck = 1; txDonePulse = 1; cyc();
    chk("R5 ack rx, tx rises", {6'b0, irqReq, irqSide}, 8'b11);
    rdRxBuf = 1; cyc();
    rxArrivePulse = 1; cyc();
    chk("R10 rx first", {6'b0, irqReq, irqSide}, 8'b10);
    intAck = 1; cyc();
    chk("R5 only rx cleared", {6'b0, irqReq, irqSide}, 8'b11);
    intAck = 1; cyc();
    chk("R5 tx cleared", {7'b0, irqReq}, 8'd0);
    intAck = 1; cyc();
    chk("R5 stray ack", {4'b0, rxIe, rxDone, txIe, txDone}, 8'b1111);

    // R8 I/O reset
    wrIe(1, 1'b0); wrIe(1, 1'b1);
    chk("R8 setup", {7'b0, irqReq}, 8'd1);
    ioReset = 1; cyc();
    chk("R8 cleared", {7'b0, irqReq}, 8'd0);
    chk("R8 flags kept", {4'b0, rxIe, rxDone, txIe, txDone}, 8'b1111);
    repeat (3) cyc();
    chk("R8 no re-request", {7'b0, irqReq}, 8'd0);

    // R9 initialise write beats same-cycle events
    wrTxBuf = 1; cyc();
    wrIe(0, 1'b0); wrIe(0, 1'b1);
    wrBootReg = 1; rxArrivePulse = 1; wrTxBuf = 1; wrTxCsr = 1; wrIeBit = 1; cyc();
    chk("R9 boot state", {3'b0, irqReq, rxIe, rxDone, txIe, txDone}, 8'b00001);

    // sweep: old enable, ready, new enable on each side
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 8; k++) begin
        logic oIe, rdy, nIe, exp;
        {oIe, rdy, nIe} = k[2:0];
        wrBootReg = 1; cyc();
        if (s == 1 && !rdy) begin wrTxBuf = 1; cyc(); end
        if (s == 0 && rdy) begin rxArrivePulse = 1; cyc(); end
        wrIe(s, oIe);
        if (irqReq) begin intAck = 1; cyc(); end
        chk("R5 sweep quiet", {7'b0, irqReq}, 8'd0);
        wrIe(s, nIe);
        exp = nIe & rdy & ~(oIe & rdy);
        chk(s == 0 ? "R3 sweep rx" : "R3 sweep tx", {7'b0, irqReq}, {7'b0, exp});
        if (exp) chk("R10 sweep side", {7'b0, irqSide}, s[7:0]);
      end
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule